// File: doc/BRIEF.md
# Breakpoint Value Match Comparator

This block decides, for one hardware breakpoint, whether the core's current execution context hits the programmed breakpoint value. A 64-bit value word and a 4-bit type code are held by the surrounding debug logic and presented on the ports. The type code selects how the value word is read. It can be an instruction address, a single context identifier, a virtual machine identifier (VMID), or a combination of two of these. Each reading has its own bit placement, and some have a width that depends on the current regime.

The live side supplies the current instruction address, a flag for a 32-bit translation regime, the lower and hypervisor-level context identifier registers, and the current VMID. It also supplies configuration flags for large-address support, 16-bit VMIDs, host mode, a 64-bit hypervisor level, and the presence of the hypervisor level, along with the current exception level and the trap-general flag. A single registered output pulses high one clock after a matching set of inputs is presented while the enable input is high. Linking to other breakpoints, exception generation and privilege filtering are handled elsewhere.

Top module: `bkv_match`

## Requirements
- R1: The type code bits [3:1] select the reading of the value word. 000 and 010 select address. 001 selects one context ID chosen by the host rule (R5). 011 selects the lower context ID. 100 selects a VMID. 101 selects a VMID plus the lower context ID. 110 selects the hypervisor-level context ID. 111 selects both context IDs. Type bit 0 takes no part.
- R2: In address mode with a 64-bit regime and large addresses off, value bits [48:2] are compared with address bits [48:2]. Bits [1:0] and [63:49] of both the value and the address are ignored.
- R3: With large-address support on and a 64-bit regime, the address compare extends over bits [52:2]. Bits [63:53] stay ignored.
- R4: With the 32-bit regime flag set, only bits [31:2] are compared. Value bits [48:32] and address bits [63:32] are ignored, whatever the large-address flag says.
- R5: For type 001x, the compare uses the hypervisor-level context ID when host mode is on and either the exception level is 2, or trap-general is set with exception level 0. Otherwise it uses the lower context ID. Either way the value bits used are [31:0].
- R6: The lower context ID is compared with value bits [31:0] (type 011x). The hypervisor-level context ID is compared with value bits [63:32] (type 110x).
- R7: The VMID compares value bits [39:32] with VMID bits [7:0]. Value bits [47:40] are compared with VMID bits [15:8] only when 16-bit VMID mode is on and the hypervisor level runs in 64-bit state.
- R8: Type 101x matches only when the VMID (R7) and the lower context ID (value bits [31:0]) both match in the same cycle.
- R9: Type 111x matches only when the lower context ID matches value bits [31:0] and the hypervisor context ID matches value bits [63:32] in the same cycle.
- R10: When the hypervisor level is absent, types 011x, 110x and 111x never match.
- R11: The match output is registered. It is high in the cycle after a matching input set is presented with enable high. It is low after any cycle with enable low, and it is low out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Match enable |
| bp_type | input | 4 | Breakpoint type code |
| bp_value | input | 64 | Breakpoint value word |
| pc | input | 64 | Current instruction address |
| regime32 | input | 1 | Address is matched in a 32-bit regime |
| ctx_lo | input | 32 | Lower-level context ID register |
| ctx_hi | input | 32 | Hypervisor-level context ID register |
| vmid | input | 16 | Current VMID |
| cfg_lva | input | 1 | Large-address support enabled |
| cfg_vmid16 | input | 1 | 16-bit VMID mode enabled |
| cfg_host | input | 1 | Host mode enabled |
| hyp_a64 | input | 1 | Hypervisor level runs in 64-bit state |
| hyp_present | input | 1 | Hypervisor level exists |
| cur_el | input | 2 | Current exception level |
| tge | input | 1 | Trap-general flag |
| hit | output | 1 | Registered match pulse |

## Verification
The bench builds the block with its default parameters: a 64-bit value word and address, 32-bit context IDs, a 16-bit VMID, an address field topping out at bit 48, and a large-address extension up to bit 52. With these sizes, every field boundary named in the requirements is a fixed bit that a directed vector can flip. These boundaries are bits 1:0, 31/32, 48/49, 52/53 and the VMID byte split at 40. Each flip is placed so that it decides between hit and miss.

// File: rtl/bkv_pkg.sv
package bkv_pkg;
    localparam int BKV_VAL_W  = 64;
    localparam int BKV_TYPE_W = 4;

    typedef enum logic [2:0] {
        K_NONE,
        K_ADDR,
        K_CTX_SEL,
        K_CTX_LO,
        K_VMID,
        K_VMID_CTX,
        K_CTX_HI,
        K_CTX_PAIR
    } bkv_kind_t;
endpackage

// File: rtl/bkv_addr_cmp.sv
module bkv_addr_cmp #(
    parameter int ADDR_W     = 64,
    parameter int LSB        = 2,
    parameter int VA_TOP     = 48,
    parameter int LVA_TOP    = 52,
    parameter int NARROW_TOP = 31
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic [ADDR_W-1:0] val,
    input  logic              lva,
    input  logic              narrow,
    output logic              eq
);
    logic [ADDR_W-1:0] care;

    always_comb begin
        for (int i = 0; i < ADDR_W; i++) begin
            if (i < LSB) begin
                care[i] = 1'b0;
            end else if (narrow) begin
                care[i] = (i <= NARROW_TOP);
            end else begin
                care[i] = (i <= VA_TOP) || (lva && (i <= LVA_TOP));
            end
        end
    end

    assign eq = (((pc ^ val) & care) == '0);
endmodule

// File: rtl/bkv_field_cmp.sv
module bkv_field_cmp #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] care,
    output logic         eq
);
    assign eq = (((a ^ b) & care) == '0);
endmodule

// File: rtl/bkv_decode.sv
module bkv_decode
    import bkv_pkg::*;
#(
    parameter int TYPE_W = BKV_TYPE_W
) (
    input  logic [TYPE_W-1:0] bp_type,
    input  logic              hyp_present,
    output bkv_kind_t         kind
);
    always_comb begin
        kind = K_NONE;
        unique case (bp_type[3:1])
            3'b000, 3'b010: kind = K_ADDR;
            3'b001:         kind = K_CTX_SEL;
            3'b011:         kind = hyp_present ? K_CTX_LO : K_NONE;
            3'b100:         kind = K_VMID;
            3'b101:         kind = K_VMID_CTX;
            3'b110:         kind = hyp_present ? K_CTX_HI : K_NONE;
            3'b111:         kind = hyp_present ? K_CTX_PAIR : K_NONE;
            default:        kind = K_NONE;
        endcase
    end
endmodule

// File: rtl/bkv_match.sv
module bkv_match
    import bkv_pkg::*;
#(
    parameter int VAL_W      = BKV_VAL_W,
    parameter int TYPE_W     = BKV_TYPE_W,
    parameter int CTX_W      = 32,
    parameter int VMID_W     = 16,
    parameter int VMID_LSB   = 32,
    parameter int VA_TOP     = 48,
    parameter int LVA_TOP    = 52,
    parameter int ADDR_LSB   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [TYPE_W-1:0] bp_type,
    input  logic [VAL_W-1:0]  bp_value,
    input  logic [VAL_W-1:0]  pc,
    input  logic              regime32,
    input  logic [CTX_W-1:0]  ctx_lo,
    input  logic [CTX_W-1:0]  ctx_hi,
    input  logic [VMID_W-1:0] vmid,
    input  logic              cfg_lva,
    input  logic              cfg_vmid16,
    input  logic              cfg_host,
    input  logic              hyp_a64,
    input  logic              hyp_present,
    input  logic [1:0]        cur_el,
    input  logic              tge,
    output logic              hit
);
    localparam int NCTX       = 2;
    localparam int NARROW_TOP = CTX_W - 1;
    localparam int VMID_HALF  = VMID_W / 2;

    bkv_kind_t        kind;
    logic             addr_eq;
    logic [NCTX-1:0]  ctx_eq;
    logic             vmid_eq;
    logic             use_hi;
    logic             sel_eq;
    logic             hit_d;
    logic [NCTX-1:0][CTX_W-1:0] ctx_bus;
    logic [VMID_W-1:0] vmid_care;

    bkv_decode #(.TYPE_W(TYPE_W)) i_decode (
        .bp_type     (bp_type),
        .hyp_present (hyp_present),
        .kind        (kind)
    );

    bkv_addr_cmp #(
        .ADDR_W     (VAL_W),
        .LSB        (ADDR_LSB),
        .VA_TOP     (VA_TOP),
        .LVA_TOP    (LVA_TOP),
        .NARROW_TOP (NARROW_TOP)
    ) i_addr (
        .pc     (pc),
        .val    (bp_value),
        .lva    (cfg_lva),
        .narrow (regime32),
        .eq     (addr_eq)
    );

    assign ctx_bus = {ctx_hi, ctx_lo};

    // One comparator per context slot: slot 0 low word, slot 1 high word.
    for (genvar g = 0; g < NCTX; g++) begin : g_ctx
        bkv_field_cmp #(.W(CTX_W)) i_ctx (
            .a    (ctx_bus[g]),
            .b    (bp_value[g*CTX_W +: CTX_W]),
            .care ({CTX_W{1'b1}}),
            .eq   (ctx_eq[g])
        );
    end

    // Single-context type: value always in the low word, register picked by host rule.
    assign use_hi = cfg_host && ((cur_el == 2'd2) || (tge && (cur_el == 2'd0)));

    bkv_field_cmp #(.W(CTX_W)) i_sel (
        .a    (use_hi ? ctx_hi : ctx_lo),
        .b    (bp_value[CTX_W-1:0]),
        .care ({CTX_W{1'b1}}),
        .eq   (sel_eq)
    );

    assign vmid_care = {{(VMID_W-VMID_HALF){cfg_vmid16 && hyp_a64}}, {VMID_HALF{1'b1}}};

    bkv_field_cmp #(.W(VMID_W)) i_vmid (
        .a    (vmid),
        .b    (bp_value[VMID_LSB +: VMID_W]),
        .care (vmid_care),
        .eq   (vmid_eq)
    );

    always_comb begin
        hit_d = 1'b0;
        unique case (kind)
            K_ADDR:     hit_d = addr_eq;
            K_CTX_SEL:  hit_d = sel_eq;
            K_CTX_LO:   hit_d = ctx_eq[0];
            K_VMID:     hit_d = vmid_eq;
            K_VMID_CTX: hit_d = vmid_eq && ctx_eq[0];
            K_CTX_HI:   hit_d = ctx_eq[1];
            K_CTX_PAIR: hit_d = ctx_eq[0] && ctx_eq[1];
            K_NONE:     hit_d = 1'b0;
            default:    hit_d = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hit <= 1'b0;
        end else begin
            hit <= en && hit_d;
        end
    end
endmodule

// File: rtl/bkv_match_chk.sv
module bkv_match_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        en,
    input logic [3:0]  bp_type,
    input logic [63:0] bp_value,
    input logic [63:0] pc,
    input logic        regime32,
    input logic [31:0] ctx_lo,
    input logic [31:0] ctx_hi,
    input logic [15:0] vmid,
    input logic        cfg_lva,
    input logic        hyp_present,
    input logic        hit
);
    AST_EN_LOW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !hit); // R11

    AST_ADDR_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !bp_type[3] && !bp_type[1] && !regime32 && !cfg_lva
         && pc[48:2] == bp_value[48:2]) |=> hit); // R2

    AST_NO_HYP_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (!hyp_present && (bp_type[3:1] == 3'b011 || bp_type[3:1] == 3'b110
                          || bp_type[3:1] == 3'b111)) |=> !hit); // R10

    AST_PAIR_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        (en && bp_type[3:1] == 3'b111 && hyp_present) |=>
        (hit == ($past(ctx_lo) == $past(bp_value[31:0])
                 && $past(ctx_hi) == $past(bp_value[63:32])))); // R9

    AST_VMID_LOW_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (en && bp_type[3:1] == 3'b100 && vmid[7:0] != bp_value[39:32]) |=> !hit); // R7

    AST_VMID_CTX_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        (en && bp_type[3:1] == 3'b101 && ctx_lo != bp_value[31:0]) |=> !hit); // R8
endmodule

bind bkv_match bkv_match_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (en),
    .bp_type     (bp_type),
    .bp_value    (bp_value),
    .pc          (pc),
    .regime32    (regime32),
    .ctx_lo      (ctx_lo),
    .ctx_hi      (ctx_hi),
    .vmid        (vmid),
    .cfg_lva     (cfg_lva),
    .hyp_present (hyp_present),
    .hit         (hit)
);

// File: tb/test_bkv_match.sv
module test_bkv_match;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en;
    logic [3:0]  bp_type;
    logic [63:0] bp_value;
    logic [63:0] pc;
    logic        regime32;
    logic [31:0] ctx_lo;
    logic [31:0] ctx_hi;
    logic [15:0] vmid;
    logic        cfg_lva;
    logic        cfg_vmid16;
    logic        cfg_host;
    logic        hyp_a64;
    logic        hyp_present;
    logic [1:0]  cur_el;
    logic        tge;
    logic        hit;

    int total = 0;
    int bad = 0;
    bit done = 0;

    localparam logic [63:0] PC_A = 64'h0000_1234_5678_9ABC;
    localparam logic [31:0] CL   = 32'hAAAA_0001;
    localparam logic [31:0] CH   = 32'h5555_0002;

    always #10 clk = ~clk;

    bkv_match i_bkv_match (
        .clk(clk), .rst_n(rst_n), .en(en), .bp_type(bp_type), .bp_value(bp_value),
        .pc(pc), .regime32(regime32), .ctx_lo(ctx_lo), .ctx_hi(ctx_hi), .vmid(vmid),
        .cfg_lva(cfg_lva), .cfg_vmid16(cfg_vmid16), .cfg_host(cfg_host),
        .hyp_a64(hyp_a64), .hyp_present(hyp_present), .cur_el(cur_el), .tge(tge),
        .hit(hit)
    );

    task automatic defaults();
        en = 1'b1; bp_type = 4'b0000; bp_value = '0; pc = '0; regime32 = 1'b0;
        ctx_lo = CL; ctx_hi = CH; vmid = 16'h0000; cfg_lva = 1'b0; cfg_vmid16 = 1'b0;
        cfg_host = 1'b0; hyp_a64 = 1'b1; hyp_present = 1'b1; cur_el = 2'd1; tge = 1'b0;
    endtask

    // Inputs are set at a falling edge; result appears after the next rising edge.
    task automatic step_chk(input logic exp, input string tag);
        @(negedge clk);
        total++;
        if (hit !== exp) begin
            bad++;
            $display("FAIL %s: hit=%0b expected=%0b", tag, hit, exp);
        end
    endtask

    task automatic t_reset();
        total++;
        if (hit !== 1'b0) begin
            bad++;
            $display("FAIL R11 reset: hit=%0b expected=0", hit);
        end
    endtask

    task automatic t_addr();
        defaults(); pc = PC_A; bp_value = PC_A;             step_chk(1'b1, "R2 exact address");
        bp_type = 4'b0101;                                  step_chk(1'b1, "R1 type 0101 is address");
        bp_type = 4'b0000; bp_value = PC_A ^ 64'h4;         step_chk(1'b0, "R2 bit2 differs");
        bp_value = PC_A ^ 64'h3;                            step_chk(1'b1, "R2 bits 1:0 ignored");
        bp_value = PC_A ^ 64'hFFE0_0000_0000_0000;          step_chk(1'b1, "R2 bits 63:53 ignored");
        bp_value = PC_A ^ (64'h1 << 48);                    step_chk(1'b0, "R2 bit48 differs");
        bp_value = PC_A ^ (64'h1 << 50);                    step_chk(1'b1, "R2 bits 52:49 ignored without lva");
    endtask

    task automatic t_lva();
        defaults(); cfg_lva = 1'b1; pc = PC_A;
        bp_value = PC_A ^ (64'h1 << 50);                    step_chk(1'b0, "R3 bit50 compared with lva");
        bp_value = PC_A ^ (64'h1 << 52);                    step_chk(1'b0, "R3 bit52 compared with lva");
        bp_value = PC_A ^ (64'h1 << 53);                    step_chk(1'b1, "R3 bit53 still ignored");
    endtask

    task automatic t_narrow();
        defaults(); regime32 = 1'b1; cfg_lva = 1'b1;
        pc = 64'hFFFF_0000_8765_4320; bp_value = 64'h0001_FFFF_8765_4320;
                                                            step_chk(1'b1, "R4 upper bits ignored in 32-bit regime");
        bp_value = bp_value ^ (64'h1 << 31);                step_chk(1'b0, "R4 bit31 compared");
    endtask

    task automatic t_ctx_sel();
        defaults(); bp_type = 4'b0010; bp_value = {32'h0, CH};
        step_chk(1'b0, "R5 host off uses lower");
        bp_value = {32'h0, CL};                             step_chk(1'b1, "R5 host off lower match");
        cfg_host = 1'b1; cur_el = 2'd2; bp_value = {32'h0, CH};
                                                            step_chk(1'b1, "R5 host at EL2 uses hyp");
        cur_el = 2'd0; tge = 1'b1;                          step_chk(1'b1, "R5 host tge EL0 uses hyp");
        cur_el = 2'd1;                                      step_chk(1'b0, "R5 host tge EL1 uses lower");
    endtask

    task automatic t_ctx_single();
        defaults(); bp_type = 4'b0110; bp_value = {CH, CL}; step_chk(1'b1, "R6 lower ctx match");
        bp_value = {CL, CH};                                step_chk(1'b0, "R6 lower ctx reads low word");
        bp_type = 4'b1100; bp_value = {CH, 32'h0};          step_chk(1'b1, "R6 hyp ctx in high word");
        bp_value = {CL, CH};                                step_chk(1'b0, "R6 hyp ctx mismatch");
        hyp_present = 1'b0; bp_value = {CH, 32'h0};         step_chk(1'b0, "R10 type 110 without hyp");
        bp_type = 4'b0110; bp_value = {32'h0, CL};          step_chk(1'b0, "R10 type 011 without hyp");
    endtask

    task automatic t_vmid();
        defaults(); bp_type = 4'b1000; vmid = 16'h3C5A;
        bp_value = {16'h0, 16'h775A, 32'h0};                step_chk(1'b1, "R7 8-bit vmid ignores upper byte");
        cfg_vmid16 = 1'b1;                                  step_chk(1'b0, "R7 16-bit vmid compares upper");
        hyp_a64 = 1'b0;                                     step_chk(1'b1, "R7 32-bit hyp keeps 8-bit vmid");
        hyp_a64 = 1'b1; bp_value = {16'h0, 16'h3C5A, 32'h0};
                                                            step_chk(1'b1, "R7 16-bit vmid match");
        bp_value = {16'h0, 16'h3C5B, 32'h0};                step_chk(1'b0, "R7 low byte mismatch");
    endtask

    task automatic t_pairs();
        defaults(); bp_type = 4'b1010; vmid = 16'h0011;
        bp_value = {16'h0, 16'h0011, CH};                   step_chk(1'b0, "R8 vmid ok ctx wrong");
        bp_value = {16'h0, 16'h0012, CL};                   step_chk(1'b0, "R8 ctx ok vmid wrong");
        bp_value = {16'h0, 16'h0011, CL};                   step_chk(1'b1, "R8 both match");
        bp_type = 4'b1110; bp_value = {CH, CL};             step_chk(1'b1, "R9 both ctx match");
        bp_value = {CH, CH};                                step_chk(1'b0, "R9 lower wrong");
        bp_value = {CL, CL};                                step_chk(1'b0, "R9 hyp wrong");
        hyp_present = 1'b0; bp_value = {CH, CL};            step_chk(1'b0, "R10 type 111 without hyp");
    endtask

    task automatic t_enable();
        defaults(); pc = PC_A; bp_value = PC_A; en = 1'b0; step_chk(1'b0, "R11 enable low");
        en = 1'b1;                                          step_chk(1'b1, "R11 enable high");
        bp_value = PC_A ^ 64'h4;                            step_chk(1'b0, "R11 drops next cycle");
    endtask

    initial begin
        defaults();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_addr();
        t_lva();
        t_narrow();
        t_ctx_sel();
        t_ctx_single();
        t_vmid();
        t_pairs();
        t_enable();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule